// File: doc/BRIEF.md
# Selector-Based Segment Address Translator

This block turns a logical address into a 32-bit linear address. The logical address is a 16-bit selector plus a 32-bit offset. The selector names an 8-byte descriptor in one of two in-memory tables, a global one and a local one. The block computes where that descriptor sits and reads it as two 32-bit words over a valid/ready memory read port. It keeps the base, limit and access rights of the most recent descriptor. It then adds the base to the offset and compares the offset with the limit. With paging off, the linear address is used directly as the physical address.

A request is accepted when `req_valid_i` and `req_ready_o` are both high. A selector equal to the one already held is a hit: the block answers one cycle later and makes no memory read. Any other selector is a miss: the block fetches the descriptor, replaces the held copy, and answers one cycle after the second read completes. An offset above the limit makes a fault response, and that response carries no address. The requested privilege bits are passed through unchanged.

Top module: `seg_xlate`

## Requirements
- R1: Selector layout: bits [15:3] are the descriptor index, bit [2] is the table select (0 = global table at `gdt_base_i`, 1 = local table at `ldt_base_i`), and bits [1:0] are the requested privilege. The privilege field is returned unchanged on `rsp_rpl_o`.
- R2: The first memory read of a fetch uses the address (table base + index * 8) modulo 2^32.
- R3: A fetch is exactly two reads. The low word is read at the descriptor address, then the high word at that address + 4. While `mem_valid_o` is high and `mem_ready_i` is low, the request and its address stay unchanged.
- R4: Descriptor layout: the low word is the 32-bit segment base. In the high word, bits [19:0] hold the limit and bits [31:20] hold the access rights. The access rights are returned on `rsp_acc_o`.
- R5: The linear address is (base + offset) modulo 2^32. On a miss, `rsp_valid_o` is high for the one cycle after the clock edge that completes the second read. Example: base 00030000h with offset 00002000h gives 00032000h.
- R6: When the offset is greater than the limit, `rsp_fault_o` is 1 and `rsp_lin_o` is 0. An offset equal to the limit does not fault.
- R7: A request whose selector equals the held selector makes no memory read and responds in the cycle right after acceptance.
- R8: A request with any other selector value reloads the held descriptor. This includes the same index with the other table select, and a change in the privilege bits only.
- R9: After reset `req_ready_o` is 1 and `rsp_valid_o` and `mem_valid_o` are 0. No descriptor is held, so the first request always fetches, even for selector 0000h.
- R10: While a fetch is in progress `req_ready_o` is 0. A request offered during that time is ignored and does not change the response or the held descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base_i | input | 32 | Base address of the global descriptor table |
| ldt_base_i | input | 32 | Base address of the local descriptor table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_sel_i | input | 16 | Selector |
| req_off_i | input | 32 | Offset within the segment |
| mem_valid_o | output | 1 | Memory read request valid |
| mem_ready_i | input | 1 | Memory accepts the read; data is valid this cycle |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rdata_i | input | 32 | Memory read data |
| rsp_valid_o | output | 1 | Response valid (one cycle) |
| rsp_fault_o | output | 1 | Offset exceeded the limit |
| rsp_lin_o | output | 32 | Linear address, 0 on fault |
| rsp_acc_o | output | 12 | Access rights of the descriptor used |
| rsp_rpl_o | output | 2 | Requested privilege from the selector |

## Verification
Selectors are drawn from a small pool, so that cached hits and reloads both occur often. A hit must show no memory traffic and one-cycle latency. A miss must show two ordered reads at the computed addresses. Directed cases flip only the table-select bit or only the privilege bits, to show that any selector change reloads the descriptor. Other directed cases put the offset at the limit and one above it, to locate the exact fault boundary. Another case places the local table near the top of the address space, so that the descriptor address wraps. Random memory stalls, and a foreign request offered during a stalled fetch, show that the address is held steady and that requests are refused while busy.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int IDX_LSB    = 3;
  localparam int IDX_W      = SEL_W - IDX_LSB;
  localparam int TI_BIT     = 2;
  localparam int RPL_W      = 2;
  localparam int LIM_W      = 20;
  localparam int ACC_W      = 12;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = ADDR_W / 8;

  typedef struct packed {
    logic [ACC_W-1:0]  acc;
    logic [LIM_W-1:0]  lim;
    logic [ADDR_W-1:0] base;
  } seg_desc_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_state_t;

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1:IDX_LSB];
  endfunction

  function automatic logic sel_is_local(input logic [SEL_W-1:0] sel);
    return sel[TI_BIT];
  endfunction

  function automatic logic [RPL_W-1:0] sel_rpl(input logic [SEL_W-1:0] sel);
    return sel[RPL_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] tbase,
                                                  input logic [SEL_W-1:0]  sel);
    logic [ADDR_W-1:0] scaled;
    scaled = ADDR_W'(sel_index(sel)) * ADDR_W'(DESC_BYTES);
    return tbase + scaled;
  endfunction

  function automatic seg_desc_t unpack_desc(input logic [ADDR_W-1:0] lo_word,
                                            input logic [ADDR_W-1:0] hi_word);
    seg_desc_t d;
    d.base = lo_word;
    d.lim  = hi_word[LIM_W-1:0];
    d.acc  = hi_word[ADDR_W-1:ADDR_W-ACC_W];
    return d;
  endfunction

  function automatic logic over_limit(input logic [ADDR_W-1:0] off,
                                      input logic [LIM_W-1:0]  lim);
    return off > ADDR_W'(lim);
  endfunction

  function automatic logic [ADDR_W-1:0] lin_sum(input logic [ADDR_W-1:0] base,
                                                input logic [ADDR_W-1:0] off);
    return base + off;
  endfunction

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] load_sel_i,
  input  seg_desc_t        load_desc_i,
  input  logic [SEL_W-1:0] lookup_sel_i,
  output logic             hit_o,
  output seg_desc_t        desc_o
);

  logic             vld_q;
  logic [SEL_W-1:0] sel_q;
  seg_desc_t        desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sel_q  <= '0;
      desc_q <= '0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      sel_q  <= load_sel_i;
      desc_q <= load_desc_i;
    end
  end

  assign hit_o  = vld_q && (sel_q == lookup_sel_i);
  assign desc_o = desc_q;

  // R8: a freshly loaded selector is recognised on the following cycle
  assert_load_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_sel_i == lookup_sel_i) |=> vld_q);

endmodule

// File: rtl/seg_fetch_seq.sv
module seg_fetch_seq
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] lo_word_o
);

  fetch_state_t      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] lo_q;
  logic              lo_phase;
  logic              hi_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        FS_IDLE: if (start_i) begin
          st_q   <= FS_LO;
          addr_q <= start_addr_i;
        end
        FS_LO: if (mem_ready_i) begin
          lo_q   <= mem_rdata_i;
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          st_q   <= FS_HI;
        end
        FS_HI: if (mem_ready_i) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign lo_phase    = (st_q == FS_LO);
  assign hi_phase    = (st_q == FS_HI);
  assign mem_valid_o = lo_phase || hi_phase;
  assign mem_addr_o  = addr_q;
  assign busy_o      = mem_valid_o;
  assign done_o      = hi_phase && mem_ready_i;
  assign lo_word_o   = lo_q;

  // R3: a stalled read keeps its request and address
  assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

  // R3: the high-word read only ever follows the low-word read
  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_phase) |-> $past(lo_phase && mem_ready_i));

  // R3: high word sits one word above the low word
  assert_hi_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_phase) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)));

endmodule

// File: rtl/seg_resp_unit.sv
module seg_resp_unit
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  seg_desc_t         desc_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [RPL_W-1:0]  rpl_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] rsp_lin_o,
  output logic [ACC_W-1:0]  rsp_acc_o,
  output logic [RPL_W-1:0]  rsp_rpl_o
);

  logic              viol;
  logic [ADDR_W-1:0] sum;

  assign viol = over_limit(off_i, desc_i.lim);
  assign sum  = lin_sum(desc_i.base, off_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_lin_o   <= '0;
      rsp_acc_o   <= '0;
      rsp_rpl_o   <= '0;
    end else begin
      rsp_valid_o <= fire_i;
      if (fire_i) begin
        rsp_fault_o <= viol;
        rsp_lin_o   <= viol ? '0 : sum;
        rsp_acc_o   <= desc_i.acc;
        rsp_rpl_o   <= rpl_i;
      end
    end
  end

  // R6: a faulting response never carries an address
  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_lin_o == '0));

  // R5: every accepted translation produces a response one cycle later
  assert_fire_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> rsp_valid_o);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [ADDR_W-1:0] req_off_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] rsp_lin_o,
  output logic [ACC_W-1:0]  rsp_acc_o,
  output logic [RPL_W-1:0]  rsp_rpl_o
);

  logic              fetch_busy;
  logic              fetch_done;
  logic [ADDR_W-1:0] lo_word;
  logic              cache_hit;
  seg_desc_t         cache_desc;
  seg_desc_t         fetched_desc;
  logic              accept;
  logic              hit_accept;
  logic              miss_accept;
  logic [ADDR_W-1:0] tbase;
  logic [ADDR_W-1:0] daddr;
  logic [SEL_W-1:0]  pend_sel_q;
  logic [ADDR_W-1:0] pend_off_q;
  logic              fire;
  seg_desc_t         fire_desc;
  logic [ADDR_W-1:0] fire_off;
  logic [RPL_W-1:0]  fire_rpl;

  assign req_ready_o  = !fetch_busy;
  assign accept       = req_valid_i && req_ready_o;
  assign hit_accept   = accept && cache_hit;
  assign miss_accept  = accept && !cache_hit;
  assign tbase        = sel_is_local(req_sel_i) ? ldt_base_i : gdt_base_i;
  assign daddr        = desc_addr(tbase, req_sel_i);
  assign fetched_desc = unpack_desc(lo_word, mem_rdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sel_q <= '0;
      pend_off_q <= '0;
    end else if (miss_accept) begin
      pend_sel_q <= req_sel_i;
      pend_off_q <= req_off_i;
    end
  end

  assign fire      = hit_accept || fetch_done;
  assign fire_desc = fetch_done ? fetched_desc : cache_desc;
  assign fire_off  = fetch_done ? pend_off_q : req_off_i;
  assign fire_rpl  = fetch_done ? sel_rpl(pend_sel_q) : sel_rpl(req_sel_i);

  seg_desc_cache u_cache (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (fetch_done),
    .load_sel_i   (pend_sel_q),
    .load_desc_i  (fetched_desc),
    .lookup_sel_i (req_sel_i),
    .hit_o        (cache_hit),
    .desc_o       (cache_desc)
  );

  seg_fetch_seq u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (miss_accept),
    .start_addr_i (daddr),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (fetch_busy),
    .done_o       (fetch_done),
    .lo_word_o    (lo_word)
  );

  seg_resp_unit u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .desc_i      (fire_desc),
    .off_i       (fire_off),
    .rpl_i       (fire_rpl),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_lin_o   (rsp_lin_o),
    .rsp_acc_o   (rsp_acc_o),
    .rsp_rpl_o   (rsp_rpl_o)
  );

  // R7: a hit never starts a memory read
  assert_hit_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> !mem_valid_o);

  // R2: a miss starts reading at the computed descriptor address
  assert_miss_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_accept |=> (mem_valid_o && mem_addr_o == $past(daddr)));

  // R10: accepting requests and fetching are mutually exclusive
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_valid_o);

  // R10: a hit and a fetch completion never compete for the response
  assert_single_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_accept && fetch_done));

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] gdt_base_i;
  logic [31:0] ldt_base_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [15:0] req_sel_i;
  logic [31:0] req_off_i;
  logic        mem_valid_o;
  logic        mem_ready_i;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic        rsp_valid_o;
  logic        rsp_fault_o;
  logic [31:0] rsp_lin_o;
  logic [11:0] rsp_acc_o;
  logic [1:0]  rsp_rpl_o;

  always #5 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .gdt_base_i(gdt_base_i), .ldt_base_i(ldt_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_sel_i(req_sel_i),
    .req_off_i(req_off_i), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_fault_o(rsp_fault_o), .rsp_lin_o(rsp_lin_o), .rsp_acc_o(rsp_acc_o),
    .rsp_rpl_o(rsp_rpl_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int nidx = 0;
  int hs_cnt = 0;
  int hs2_idx = 0;
  int stall_left = 0;
  bit rnd_ready = 1'b0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] hs_addr0 = '0;
  logic [31:0] hs_addr1 = '0;
  bit m_vld = 1'b0;
  logic [15:0] m_sel = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] x;
    if (a == 32'h0001_0100) return 32'h0003_0000;
    if (a == 32'h0001_0104) return {12'h093, 20'h0FFFF};
    x = a ^ (a >> 7);
    return x * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  always_comb mem_rdata_i = mem_word(mem_addr_o);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory side: ready generation, handshake log, stall stability (R3)
  always @(negedge clk) begin
    nidx++;
    if (stall_left > 0) begin
      mem_ready_i = 1'b0;
      stall_left--;
    end else begin
      mem_ready_i = rnd_ready ? 1'($urandom % 2) : 1'b1;
    end
    if (prev_stall) begin
      chk(mem_valid_o, "R3", "valid held in stall", 32'(mem_valid_o), 32'd1);
      chk(mem_addr_o == prev_addr, "R3", "address held in stall", mem_addr_o, prev_addr);
    end
    prev_stall = mem_valid_o && !mem_ready_i;
    prev_addr  = mem_addr_o;
    if (mem_valid_o && mem_ready_i) begin
      if (hs_cnt == 0) hs_addr0 = mem_addr_o;
      if (hs_cnt == 1) hs_addr1 = mem_addr_o;
      hs_cnt++;
      if (hs_cnt == 2) hs2_idx = nidx;
    end
  end

  task automatic xlate(input logic [15:0] sel, input logic [31:0] off, input bit junk);
    bit exp_hit;
    logic [31:0] da, base, hiw, exp_lin;
    logic [19:0] lim;
    bit exp_fault, jdone;
    int guard;
    exp_hit = m_vld && (m_sel == sel);
    da = (sel[2] ? ldt_base_i : gdt_base_i) + {16'd0, sel[15:3], 3'b000};
    base = mem_word(da);
    hiw  = mem_word(da + 32'd4);
    lim  = hiw[19:0];
    exp_fault = off > {12'd0, lim};
    exp_lin = exp_fault ? 32'd0 : base + off;
    jdone = 1'b0;
    @(negedge clk); #1;
    chk(req_ready_o, "R10", "ready when idle", 32'(req_ready_o), 32'd1);
    hs_cnt = 0;
    if (junk) stall_left = 6;
    req_valid_i = 1'b1; req_sel_i = sel; req_off_i = off;
    @(negedge clk); #1;
    req_valid_i = 1'b0;
    if (exp_hit) begin
      chk(rsp_valid_o, "R7", "hit answers next cycle", 32'(rsp_valid_o), 32'd1);
      chk(hs_cnt == 0, "R7", "hit makes no reads", 32'(hs_cnt), 32'd0);
    end else begin
      guard = 0;
      while (!rsp_valid_o && guard < 2000) begin
        if (junk && !jdone && mem_valid_o) begin
          chk(!req_ready_o, "R10", "busy during fetch", 32'(req_ready_o), 32'd0);
          req_valid_i = 1'b1; req_sel_i = ~sel; req_off_i = ~off;
          jdone = 1'b1;
        end
        @(negedge clk); #1;
        req_valid_i = 1'b0;
        guard++;
      end
      chk(hs_cnt == 2, "R3", "miss makes two reads", 32'(hs_cnt), 32'd2);
      chk(hs_addr0 == da, "R2", "low word address", hs_addr0, da);
      chk(hs_addr1 == da + 32'd4, "R3", "high word address", hs_addr1, da + 32'd4);
      chk(nidx == hs2_idx + 1, "R5", "miss response timing", 32'(nidx), 32'(hs2_idx + 1));
    end
    chk(rsp_fault_o == exp_fault, "R6", "fault flag", 32'(rsp_fault_o), 32'(exp_fault));
    chk(rsp_lin_o == exp_lin, "R5", "linear address", rsp_lin_o, exp_lin);
    chk(rsp_acc_o == hiw[31:20], "R4", "access rights", 32'(rsp_acc_o), 32'(hiw[31:20]));
    chk(rsp_rpl_o == sel[1:0], "R1", "privilege passthrough", 32'(rsp_rpl_o), 32'(sel[1:0]));
    m_vld = 1'b1;
    m_sel = sel;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pool [6];
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid_i = 1'b0; req_sel_i = '0; req_off_i = '0;
    gdt_base_i = 32'h0001_0000; ldt_base_i = 32'h0004_0000;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready_o, "R9", "ready in reset", 32'(req_ready_o), 32'd1);
    chk(!rsp_valid_o, "R9", "no response in reset", 32'(rsp_valid_o), 32'd0);
    chk(!mem_valid_o, "R9", "no read in reset", 32'(mem_valid_o), 32'd0);
    rst_n = 1'b1;
    // empty cache: selector 0 must still fetch
    xlate(16'h0000, 32'h0000_0010, 1'b0);
    chk(hs_cnt == 2, "R9", "first request fetches", 32'(hs_cnt), 32'd2);
    // worked example and reuse
    xlate(16'h0100, 32'h0000_2000, 1'b0);
    chk(rsp_lin_o == 32'h0003_2000, "R5", "example sum", rsp_lin_o, 32'h0003_2000);
    xlate(16'h0100, 32'h0000_FFFF, 1'b0);
    xlate(16'h0100, 32'h0001_0000, 1'b0);
    chk(rsp_fault_o, "R6", "one above limit", 32'(rsp_fault_o), 32'd1);
    // table select flip and privilege-only change reload
    xlate(16'h0104, 32'h0000_0004, 1'b0);
    chk(hs_cnt == 2, "R8", "table flip reloads", 32'(hs_cnt), 32'd2);
    xlate(16'h0100, 32'h0000_0040, 1'b0);
    chk(hs_cnt == 2, "R8", "flip back reloads", 32'(hs_cnt), 32'd2);
    xlate(16'h0103, 32'h0000_0040, 1'b0);
    chk(hs_cnt == 2, "R8", "privilege change reloads", 32'(hs_cnt), 32'd2);
    // foreign request during a stalled fetch, then confirm cache kept original
    xlate(16'h0230, 32'h0000_0123, 1'b1);
    xlate(16'h0230, 32'h0000_0321, 1'b0);
    chk(hs_cnt == 0, "R10", "ignored request left cache", 32'(hs_cnt), 32'd0);
    // local table near the top: descriptor address wraps
    ldt_base_i = 32'hFFFF_FF00;
    xlate(16'h0204, 32'h0000_0800, 1'b0);
    chk(hs_addr0 == 32'h0000_0100, "R2", "wrapped address", hs_addr0, 32'h0000_0100);
    // constrained random with stalls
    pool[0] = 16'h0100; pool[1] = 16'h0104; pool[2] = 16'h1E3B;
    pool[3] = 16'h0007; pool[4] = 16'hFFF8; pool[5] = 16'h4442;
    ldt_base_i = 32'h0004_0000;
    rnd_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] off;
      off = $urandom & 32'h000F_FFFF;
      if ($urandom % 4 == 0) off = $urandom;
      xlate(pool[$urandom % 6], off, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule